// File: doc/BRIEF.md
# 8b/10b Comma Word Aligner

This block takes a recovered serial bit stream, one bit per cycle in which a bit enable is high, and cuts it into 10-bit words. It finds the word boundary by watching a sliding 10-bit window for the K28.5 control character in either running-disparity form. Whenever that character shows up at an offset that differs from the current boundary, the divide-by-10 word phase is restarted so that the character itself leaves as one complete word. The bits of the interrupted word are dropped. A character that already sits on the boundary leaves the phase untouched.

Each aligned word is registered onto a 10-bit output together with a comma flag. The flag is high only while a K28.5 word is on the output. Two receive-clock enables mark when a word may be captured. In full mode one enable pulses once per word. In half mode the two enables take turns, so each of them runs at half the word rate and stays in opposite phase to the other. Both enables come from one word strobe, so realignment can shorten a word but never adds a pulse, drops a pulse or stretches one.

Top module: `cwa_aligner`

## Requirements
- R1: A synchronous active-high reset clears the data output to 0 and holds the comma flag and both receive-clock enables low. After reset, the first word boundary falls 10 bits after the end of reset.
- R2: With no comma in the stream, every tenth enabled bit completes a word. The first received bit of the word is placed in output bit 0 and the last in bit 9. The word appears one clock cycle after its last bit is accepted.
- R3: The negative-disparity K28.5 (bit order a..j = 0011111010, which is 10'h17C on the output) is recognised and raised on the comma flag together with that word.
- R4: The positive-disparity K28.5 (a..j = 1100000101, output value 10'h283) is recognised in the same way.
- R5: A K28.5 that completes at any bit offset other than the current boundary is output at once as a full word. The interrupted partial word is discarded, and the next boundaries follow every 10 bits from that comma.
- R6: A K28.5 that lands on the current boundary leaves the word phase unchanged. A run of back-to-back commas gives exactly one word strobe per 10 bits.
- R7: The comma flag is low for every word that is not a K28.5 pattern. A comma is only searched for once at least 10 bits have been received since reset.
- R8: When full_mode is 1, enable A pulses for one cycle with every output word and enable B stays low.
- R9: When full_mode is 0, successive words are signalled alternately on enable A and enable B, starting with A after reset. The two enables are never high together.
- R10: In half mode, realigning and repeated commas keep the strict A/B alternation, with no missing and no doubled pulse.
- R11: Cycles with bit_en low have no effect: no bit is shifted, no phase advances and no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | A recovered bit is present this cycle |
| bit_in | input | 1 | Recovered serial bit, first bit of a word first |
| full_mode | input | 1 | 1: one word-rate enable; 0: two alternating half-rate enables |
| word_out | output | 10 | Aligned word, first received bit in bit 0 |
| comma_det | output | 1 | Output word is a K28.5 |
| rclk_a_en | output | 1 | Receive-clock enable A (single-cycle pulse) |
| rclk_b_en | output | 1 | Receive-clock enable B (half mode only) |

## Verification
Plain data words sent straight after reset show that the bit order and the 10-bit boundary are right, and that no comma is falsely matched. A comma inserted after a few stray bits separates immediate realignment with discarding of the partial word from detection that waits for the old boundary. Runs of aligned commas in both polarities separate phase-preserving detection from a design that restarts the phase needlessly, and the strobe count over the run is checked. The same sequences repeated in half mode, and with idle gaps between bits, show that the A/B alternation survives realignment and that idle cycles change nothing.

// File: rtl/cwa_pkg.sv
package cwa_pkg;
   localparam int unsigned CODE_W   = 10;
   localparam int unsigned NUM_PAT  = 2;
   // output bit 0 holds the first received bit
   localparam logic [CODE_W-1:0] K285_RDN = 10'h17C;
   localparam logic [CODE_W-1:0] K285_RDP = 10'h283;
   localparam logic [CODE_W-1:0] COMMA_SET [NUM_PAT] = '{K285_RDN, K285_RDP};
endpackage

// File: rtl/cwa_shifter.sv
module cwa_shifter #(
   parameter int unsigned W = 10
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         bit_en,
   input  logic         bit_in,
   output logic [W-1:0] win_next,
   output logic         win_full
);
   localparam int unsigned FILL_W = $clog2(W + 1);
   localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(W);

   logic [W-1:0]      win_q;
   logic [FILL_W-1:0] fill_q;

   assign win_next = {bit_in, win_q[W-1:1]};
   assign win_full = (fill_q >= FILL_W'(W - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         win_q  <= '0;
         fill_q <= '0;
      end else if (bit_en) begin
         win_q <= win_next;
         if (fill_q != FILL_MAX)
            fill_q <= fill_q + 1'b1;
      end
   end
endmodule

// File: rtl/cwa_comma_match.sv
module cwa_comma_match #(
   parameter int unsigned W = 10
) (
   input  logic [W-1:0] win,
   input  logic         win_full,
   output logic         hit
);
   logic [cwa_pkg::NUM_PAT-1:0] pat_eq;

   for (genvar p = 0; p < int'(cwa_pkg::NUM_PAT); p++) begin : g_pat
      assign pat_eq[p] = (win == cwa_pkg::COMMA_SET[p]);
   end

   assign hit = win_full && (|pat_eq);
endmodule

// File: rtl/cwa_word_timer.sv
module cwa_word_timer #(
   parameter int unsigned W = 10
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_en,
   input  logic comma_hit,
   output logic word_stb
);
   localparam int unsigned PH_W = $clog2(W);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(W - 1);

   logic [PH_W-1:0] ph_q;

   // an aligned comma coincides with PH_LAST, so the phase is unchanged
   assign word_stb = bit_en && ((ph_q == PH_LAST) || comma_hit);

   always_ff @(posedge clk) begin
      if (rst)
         ph_q <= '0;
      else if (word_stb)
         ph_q <= '0;
      else if (bit_en)
         ph_q <= ph_q + 1'b1;
   end
endmodule

// File: rtl/cwa_rclk_gen.sv
module cwa_rclk_gen (
   input  logic clk,
   input  logic rst,
   input  logic word_stb,
   input  logic full_mode,
   output logic en_a,
   output logic en_b
);
   logic turn_b_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         turn_b_q <= 1'b0;
         en_a     <= 1'b0;
         en_b     <= 1'b0;
      end else begin
         en_a <= 1'b0;
         en_b <= 1'b0;
         if (word_stb) begin
            if (full_mode || !turn_b_q)
               en_a <= 1'b1;
            else
               en_b <= 1'b1;
            turn_b_q <= ~turn_b_q;
         end
      end
   end
endmodule

// File: rtl/cwa_aligner.sv
module cwa_aligner #(
   parameter int unsigned WORD_W = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bit_en,
   input  logic              bit_in,
   input  logic              full_mode,
   output logic [WORD_W-1:0] word_out,
   output logic              comma_det,
   output logic              rclk_a_en,
   output logic              rclk_b_en
);
   if (WORD_W != cwa_pkg::CODE_W) begin : g_bad_width
      $error("cwa_aligner: WORD_W must equal the 8b/10b code width");
   end

   logic [WORD_W-1:0] win_next;
   logic              win_full;
   logic              comma_hit;
   logic              word_stb;

   cwa_shifter #(.W(WORD_W)) u_shift (
      .clk      (clk),
      .rst      (rst),
      .bit_en   (bit_en),
      .bit_in   (bit_in),
      .win_next (win_next),
      .win_full (win_full)
   );

   cwa_comma_match #(.W(WORD_W)) u_match (
      .win      (win_next),
      .win_full (win_full),
      .hit      (comma_hit)
   );

   cwa_word_timer #(.W(WORD_W)) u_timer (
      .clk       (clk),
      .rst       (rst),
      .bit_en    (bit_en),
      .comma_hit (comma_hit),
      .word_stb  (word_stb)
   );

   cwa_rclk_gen u_rclk (
      .clk       (clk),
      .rst       (rst),
      .word_stb  (word_stb),
      .full_mode (full_mode),
      .en_a      (rclk_a_en),
      .en_b      (rclk_b_en)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         word_out  <= '0;
         comma_det <= 1'b0;
      end else if (word_stb) begin
         word_out  <= win_next;
         comma_det <= comma_hit;
      end
   end
endmodule

// File: rtl/cwa_aligner_chk.sv
module cwa_aligner_chk #(
   parameter int unsigned W = 10
) (
   input logic         clk,
   input logic         rst,
   input logic         bit_en,
   input logic         full_mode,
   input logic [W-1:0] word_out,
   input logic         comma_det,
   input logic         rclk_a_en,
   input logic         rclk_b_en
);
   logic       pulse;
   logic [7:0] bits_q;
   logic       seen_q;
   logic       last_a_q;

   assign pulse = rclk_a_en || rclk_b_en;

   always_ff @(posedge clk) begin
      if (rst) begin
         bits_q <= '0;
      end else if (pulse) begin
         bits_q <= bit_en ? 8'd1 : 8'd0;
      end else if (bit_en && bits_q != 8'hFF) begin
         bits_q <= bits_q + 8'd1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst || full_mode) begin
         seen_q   <= 1'b0;
         last_a_q <= 1'b0;
      end else if (pulse) begin
         seen_q   <= 1'b1;
         last_a_q <= rclk_a_en;
      end
   end

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (word_out == '0 && !comma_det && !rclk_a_en && !rclk_b_en));

   assert_word_len_R2: assert property (@(posedge clk) disable iff (rst)
      (pulse && !comma_det) |-> (bits_q == 8'(W)));

   assert_realign_bound_R5: assert property (@(posedge clk) disable iff (rst)
      pulse |-> (bits_q >= 8'd1 && bits_q <= 8'(W)));

   assert_flag_code_R7: assert property (@(posedge clk) disable iff (rst)
      comma_det |-> (word_out == cwa_pkg::K285_RDN || word_out == cwa_pkg::K285_RDP));

   assert_full_single_R8: assert property (@(posedge clk) disable iff (rst)
      $past(full_mode) |-> !rclk_b_en);

   assert_enable_excl_R9: assert property (@(posedge clk) disable iff (rst)
      !(rclk_a_en && rclk_b_en));

   assert_half_alternate_R10: assert property (@(posedge clk) disable iff (rst)
      (!full_mode && $past(!full_mode) && pulse && seen_q) |-> (rclk_a_en != last_a_q));

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
      pulse |-> $past(bit_en));
endmodule

bind cwa_aligner cwa_aligner_chk #(.W(WORD_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .bit_en    (bit_en),
   .full_mode (full_mode),
   .word_out  (word_out),
   .comma_det (comma_det),
   .rclk_a_en (rclk_a_en),
   .rclk_b_en (rclk_b_en)
);

// File: tb/tb_cwa_aligner.sv
module tb_cwa_aligner;
   localparam int W = 10;
   localparam logic [W-1:0] KN = 10'h17C;
   localparam logic [W-1:0] KP = 10'h283;

   typedef struct {
      logic [W-1:0] word;
      logic         com;
      logic         on_b;
      string        tag;
   } item_t;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         bit_en = 1'b0;
   logic         bit_in = 1'b0;
   logic         full_mode = 1'b1;
   logic [W-1:0] word_out;
   logic         comma_det;
   logic         rclk_a_en;
   logic         rclk_b_en;

   int checks = 0;
   int failures = 0;
   int pulses = 0;
   bit done = 1'b0;
   string cur_tag = "R2";
   item_t exp_q[$];

   // bench-side expectation state
   logic [W-1:0] m_hist;
   int m_fill, m_ph;
   bit m_turn_b;

   always #5 clk = ~clk;

   cwa_aligner #(.WORD_W(W)) dut (
      .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
      .full_mode(full_mode), .word_out(word_out), .comma_det(comma_det),
      .rclk_a_en(rclk_a_en), .rclk_b_en(rclk_b_en)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor: pops expected words as the design signals them
   always @(negedge clk) begin
      if (!rst && (rclk_a_en || rclk_b_en)) begin
         pulses++;
         if (exp_q.size() == 0) begin
            check(1'b0, cur_tag, "unexpected word", int'(word_out), 0);
         end else begin
            item_t it;
            it = exp_q.pop_front();
            check(word_out == it.word, it.tag, "word", int'(word_out), int'(it.word));
            check(comma_det == it.com, it.tag, "comma flag", int'(comma_det), int'(it.com));
            check(rclk_b_en == it.on_b && rclk_a_en == !it.on_b, it.tag, "enable select",
                  int'({rclk_a_en, rclk_b_en}), int'({!it.on_b, it.on_b}));
         end
      end
   end

   task automatic do_reset(input logic mode);
      @(negedge clk);
      rst = 1'b1;
      bit_en = 1'b0;
      full_mode = mode;
      m_hist = '0; m_fill = 0; m_ph = 0; m_turn_b = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(word_out == '0 && !comma_det && !rclk_a_en && !rclk_b_en, "R1",
            "reset state", int'({word_out, comma_det, rclk_a_en, rclk_b_en}), 0);
   endtask

   task automatic send_bit(input logic b, input int gap);
      logic [W-1:0] nxt;
      bit hit, stb;
      item_t it;
      @(negedge clk);
      bit_en = 1'b1;
      bit_in = b;
      nxt = {b, m_hist[W-1:1]};
      hit = (m_fill >= W - 1) && (nxt == KN || nxt == KP);
      stb = (m_ph == W - 1) || hit;
      if (stb) begin
         it.word = nxt;
         it.com  = hit;
         it.on_b = full_mode ? 1'b0 : m_turn_b;
         it.tag  = (hit && m_ph != W - 1) ? "R5" : cur_tag;
         exp_q.push_back(it);
         m_turn_b = ~m_turn_b;
         m_ph = 0;
      end else begin
         m_ph++;
      end
      m_hist = nxt;
      if (m_fill < W) m_fill++;
      if (gap > 0) begin
         @(negedge clk);
         bit_en = 1'b0;
         repeat (gap - 1) @(negedge clk);
      end
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      bit_en = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic send_word(input logic [W-1:0] w, input int gap);
      for (int i = 0; i < W; i++) send_bit(w[i], gap);
   endtask

   initial begin
      int p0;
      do_reset(1'b1);
      cur_tag = "R2";
      send_word(10'h2A5, 0);
      send_word(10'h0F3, 0);
      send_word(10'h1C6, 0);
      cur_tag = "R8";
      send_word(10'h24B, 0);
      send_word(10'h319, 0);
      // stray bits, then a comma off the old boundary
      send_bit(1'b1, 0); send_bit(1'b0, 0); send_bit(1'b1, 0);
      cur_tag = "R3";
      send_word(KN, 0);
      cur_tag = "R7";
      send_word(10'h2D4, 0);
      send_word(10'h0B7, 0);
      cur_tag = "R4";
      send_word(KP, 0);
      cur_tag = "R7";
      send_word(10'h1E1, 0);
      cur_tag = "R6";
      idle(2);
      p0 = pulses;
      send_word(KN, 0); send_word(KP, 0); send_word(KN, 0); send_word(KP, 0);
      send_word(10'h2A5, 0);
      idle(3);
      check(pulses - p0 == 5, "R6", "strobes over comma run", pulses - p0, 5);
      cur_tag = "R11";
      send_word(10'h19E, 3);
      send_word(KP, 2);
      idle(12);
      check(exp_q.size() == 0, "R11", "pending words after gaps", exp_q.size(), 0);

      do_reset(1'b0);
      cur_tag = "R9";
      send_word(10'h2A5, 0);
      send_word(10'h0F3, 0);
      send_word(10'h24B, 0);
      cur_tag = "R10";
      for (int i = 0; i < 7; i++) send_bit(i[0], 0);
      send_word(KP, 0); send_word(KN, 0); send_word(KP, 0);
      send_bit(1'b0, 0); send_bit(1'b1, 0);
      send_word(KN, 0);
      send_word(10'h0B7, 0);
      send_word(10'h155, 0);
      idle(4);
      check(exp_q.size() == 0, "R10", "pending words at end", exp_q.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule